// File: doc/BRIEF.md
# Keyslot Table with Sticky Access Locks

This block stores cipher key and IV material for a crypto engine. It has sixteen slots of sixteen 32-bit words each. In every slot, words 0 to 7 hold the key, words 8 to 11 hold the original IV, and words 12 to 15 hold the updated IV. Software reaches a word by writing a pointer register that names the slot and the word, then writing or reading a data register. The engine has its own path: it writes one 128-bit quad into a slot and quad that an internal destination register selects. The cipher asks for a slot through a use port. The block answers with that slot's eight key words and a valid flag. The cipher datapath is not part of this block.

Every slot has a 7-bit access register. Bit 0 allows software read-back, bit 1 allows updates from software or the engine, and bit 2 allows cipher use. Bits 3 to 6 are reserved and are stored as written. Software can clear these bits but can never set them again, so a lock holds until reset. A per-key register holds one bit per slot. When a slot's bit is clear, only secure masters may read, update or use that slot. To erase a slot, software writes zero to each of its sixteen words in turn.

Register map on `reg_addr`: 0 to 15 select the access register of that slot, 16 the pointer, 17 the data window, 18 the engine destination, and 19 the per-key register. Other addresses read as zero, and writes to them are ignored.

Top module: `keyslot_vault`

## Requirements
- R1: After reset, every access register reads 7'h7F, the per-key register reads 16'hFFFF, the pointer and destination registers read 0, every stored word is zero, and `reg_rdata`, `use_valid` and `use_key` are zero.
- R2: A write to address 17 stores `reg_wdata` into the word named by the pointer, with the slot in pointer bits [7:4] and the word in bits [3:0]. The write happens only if the slot's update bit (bit 1) is set and the slot's per-key bit is set or `reg_secure` is high.
- R3: A read of address 17 returns the pointed-to word one cycle after `reg_rd`. It returns zero when the read bit (bit 0) is clear, or when the per-key bit is clear and `reg_secure` is low. `reg_rdata` is zero in every cycle that does not follow a read.
- R4: A software or engine write that its lock denies is dropped without any other effect. The word keeps its old value, as seen through a read or through the use port.
- R5: A write to an access register ANDs `reg_wdata[6:0]` into the stored bits. A bit that has been cleared cannot be set again before reset.
- R6: A write to the per-key register ANDs `reg_wdata[15:0]` into it, and only when `reg_secure` is high. A slot whose per-key bit is clear refuses reads, writes and use from non-secure masters and still serves secure masters.
- R7: When `eng_we` is high, the engine quad goes to the slot in destination bits [11:8], at the quad in bits [1:0]. Quad 0 is words 0 to 3, quad 1 is words 4 to 7, quad 2 is words 8 to 11 (original IV), and quad 3 is words 12 to 15 (updated IV). `eng_data[31:0]` goes to the lowest word of the quad. The write happens only if that slot's update bit is set.
- R8: One cycle after `use_req`, `use_valid` is high if the requested slot's use bit (bit 2) is set and its per-key bit is set or `use_secure` is high. `use_key` then holds key words 0 to 7, with word 0 at bits [31:0]. When `use_valid` is low, `use_key` is zero.
- R9: If a software data write and an engine quad write hit the same word in the same cycle, the engine value is stored.
- R10: The pointer and destination registers read back their fields at the bit positions above, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_secure | input | 1 | Current software master is secure |
| reg_rdata | output | 32 | Registered read data |
| eng_we | input | 1 | Engine quad write strobe |
| eng_data | input | 128 | Engine quad, lowest word in bits [31:0] |
| use_req | input | 1 | Cipher key request |
| use_slot | input | 4 | Requested slot |
| use_secure | input | 1 | Requesting master is secure |
| use_valid | output | 1 | Request granted |
| use_key | output | 256 | Key words 0 to 7 of the granted slot |

## Verification
Register writes, including writes to the access, per-key, pointer and destination registers, take effect at the rising edge where the strobe is sampled. Any read or use issued after that edge sees the new state. `reg_rdata`, `use_valid` and `use_key` are registered, so each result appears at the edge after its request and is replaced at the following edge. The bench drives every strobe at a falling edge, removes it at the next falling edge, and samples the result at that same moment. This places each sample half a cycle after the result edge. Collision cases raise both write strobes in the same falling-edge window so that they reach the same rising edge.

// File: rtl/keyslot_pkg.sv
package keyslot_pkg;
   // Access register bit positions
   localparam int unsigned ACC_READ   = 0;
   localparam int unsigned ACC_UPDATE = 1;
   localparam int unsigned ACC_USE    = 2;

   // A lock bit opens access when the slot is public or the master is secure
   function automatic logic grant(input logic lock_bit, input logic public_bit,
                                  input logic secure);
      return lock_bit & (public_bit | secure);
   endfunction
endpackage

// File: rtl/keyslot_ctl_regs.sv
module keyslot_ctl_regs #(
   parameter int unsigned NUM_SLOTS    = 16,
   parameter int unsigned ACC_W        = 7,
   parameter int unsigned SLOT_W       = 4,
   parameter int unsigned WIDX_W       = 4,
   parameter int unsigned QSEL_W       = 2,
   parameter int unsigned DST_SLOT_LSB = 8,
   parameter int unsigned REG_AW       = 5,
   parameter int unsigned CTL_W        = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [REG_AW-1:0]            wr_addr,
   input  logic [CTL_W-1:0]             wr_data,
   input  logic                         wr_secure,
   output logic [NUM_SLOTS*ACC_W-1:0]   acc_flat,
   output logic [NUM_SLOTS-1:0]         perkey_q,
   output logic [SLOT_W-1:0]            ptr_slot,
   output logic [WIDX_W-1:0]            ptr_word,
   output logic [SLOT_W-1:0]            dst_slot,
   output logic [QSEL_W-1:0]            dst_quad
);
   localparam logic [REG_AW-1:0] A_PTR  = REG_AW'(NUM_SLOTS);
   localparam logic [REG_AW-1:0] A_DST  = REG_AW'(NUM_SLOTS + 2);
   localparam logic [REG_AW-1:0] A_PKEY = REG_AW'(NUM_SLOTS + 3);

   // One sticky lock register per slot: writes may only clear bits
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_acc
      logic [ACC_W-1:0] bits_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bits_q <= '1;
         else if (wr_en && wr_addr == REG_AW'(s))
            bits_q <= bits_q & wr_data[ACC_W-1:0];
      end
      assign acc_flat[s*ACC_W +: ACC_W] = bits_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         perkey_q <= '1;
         ptr_slot <= '0;
         ptr_word <= '0;
         dst_slot <= '0;
         dst_quad <= '0;
      end else if (wr_en) begin
         if (wr_addr == A_PTR) begin
            ptr_word <= wr_data[WIDX_W-1:0];
            ptr_slot <= wr_data[WIDX_W +: SLOT_W];
         end
         if (wr_addr == A_DST) begin
            dst_quad <= wr_data[QSEL_W-1:0];
            dst_slot <= wr_data[DST_SLOT_LSB +: SLOT_W];
         end
         if (wr_addr == A_PKEY && wr_secure)
            perkey_q <= perkey_q & wr_data[NUM_SLOTS-1:0];
      end
   end
endmodule

// File: rtl/keyslot_store.sv
module keyslot_store #(
   parameter int unsigned NUM_SLOTS      = 16,
   parameter int unsigned WORD_W         = 32,
   parameter int unsigned WORDS_PER_SLOT = 16,
   parameter int unsigned QUAD_WORDS     = 4,
   parameter int unsigned KEY_WORDS      = 8,
   parameter int unsigned SLOT_W         = 4,
   parameter int unsigned WIDX_W         = 4,
   parameter int unsigned QSEL_W         = 2,
   parameter bit          ENG_PRIORITY   = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          sw_we,
   input  logic [SLOT_W-1:0]             sw_slot,
   input  logic [WIDX_W-1:0]             sw_word,
   input  logic [WORD_W-1:0]             sw_wdata,
   input  logic                          eng_we,
   input  logic [SLOT_W-1:0]             eng_slot,
   input  logic [QSEL_W-1:0]             eng_quad,
   input  logic [QUAD_WORDS*WORD_W-1:0]  eng_wdata,
   input  logic [SLOT_W-1:0]             rd_slot,
   input  logic [WIDX_W-1:0]             rd_word,
   output logic [WORD_W-1:0]             rd_data,
   input  logic [SLOT_W-1:0]             key_slot,
   output logic [KEY_WORDS*WORD_W-1:0]   key_data
);
   localparam int unsigned SLOT_BITS = WORDS_PER_SLOT * WORD_W;
   localparam int unsigned KEY_BITS  = KEY_WORDS * WORD_W;

   logic [SLOT_BITS-1:0] slot_flat [NUM_SLOTS];

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic [SLOT_BITS-1:0] data_q;
      logic                 sw_sel;
      logic                 eng_sel;
      assign sw_sel  = sw_we  && (sw_slot  == SLOT_W'(s));
      assign eng_sel = eng_we && (eng_slot == SLOT_W'(s));

      if (ENG_PRIORITY) begin : g_eng_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               data_q <= '0;
            else
               for (int w = 0; w < WORDS_PER_SLOT; w++) begin
                  if (eng_sel && int'(eng_quad) == w / QUAD_WORDS)
                     data_q[w*WORD_W +: WORD_W] <= eng_wdata[(w % QUAD_WORDS)*WORD_W +: WORD_W];
                  else if (sw_sel && int'(sw_word) == w)
                     data_q[w*WORD_W +: WORD_W] <= sw_wdata;
               end
         end
      end else begin : g_sw_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               data_q <= '0;
            else
               for (int w = 0; w < WORDS_PER_SLOT; w++) begin
                  if (sw_sel && int'(sw_word) == w)
                     data_q[w*WORD_W +: WORD_W] <= sw_wdata;
                  else if (eng_sel && int'(eng_quad) == w / QUAD_WORDS)
                     data_q[w*WORD_W +: WORD_W] <= eng_wdata[(w % QUAD_WORDS)*WORD_W +: WORD_W];
               end
         end
      end
      assign slot_flat[s] = data_q;
   end

   assign rd_data  = slot_flat[rd_slot][int'(rd_word)*WORD_W +: WORD_W];
   assign key_data = slot_flat[key_slot][KEY_BITS-1:0];
endmodule

// File: rtl/keyslot_vault.sv
module keyslot_vault #(
   parameter int unsigned NUM_SLOTS      = 16,
   parameter int unsigned WORD_W         = 32,
   parameter int unsigned WORDS_PER_SLOT = 16,
   parameter int unsigned QUAD_WORDS     = 4,
   parameter int unsigned KEY_WORDS      = 8,
   parameter int unsigned ACC_W          = 7,
   parameter int unsigned DST_SLOT_LSB   = 8,
   parameter bit          ENG_PRIORITY   = 1'b1,
   localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS),
   localparam int unsigned REG_AW   = $clog2(NUM_SLOTS + 4),
   localparam int unsigned QUAD_W   = QUAD_WORDS * WORD_W,
   localparam int unsigned KEY_BITS = KEY_WORDS * WORD_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic                 reg_rd,
   input  logic [REG_AW-1:0]    reg_addr,
   input  logic [WORD_W-1:0]    reg_wdata,
   input  logic                 reg_secure,
   output logic [WORD_W-1:0]    reg_rdata,
   input  logic                 eng_we,
   input  logic [QUAD_W-1:0]    eng_data,
   input  logic                 use_req,
   input  logic [SLOT_W-1:0]    use_slot,
   input  logic                 use_secure,
   output logic                 use_valid,
   output logic [KEY_BITS-1:0]  use_key
);
   import keyslot_pkg::*;

   localparam int unsigned WIDX_W = $clog2(WORDS_PER_SLOT);
   localparam int unsigned QSEL_W = $clog2(WORDS_PER_SLOT / QUAD_WORDS);
   localparam int unsigned PTR_W  = WIDX_W + SLOT_W;
   localparam int unsigned DST_W  = DST_SLOT_LSB + SLOT_W;
   localparam int unsigned CTL_A  = (PTR_W > DST_W) ? PTR_W : DST_W;
   localparam int unsigned CTL_B  = (NUM_SLOTS > ACC_W) ? NUM_SLOTS : ACC_W;
   localparam int unsigned CTL_W  = (CTL_A > CTL_B) ? CTL_A : CTL_B;

   localparam logic [REG_AW-1:0] A_PTR  = REG_AW'(NUM_SLOTS);
   localparam logic [REG_AW-1:0] A_DATA = REG_AW'(NUM_SLOTS + 1);
   localparam logic [REG_AW-1:0] A_DST  = REG_AW'(NUM_SLOTS + 2);
   localparam logic [REG_AW-1:0] A_PKEY = REG_AW'(NUM_SLOTS + 3);

   initial begin : p_param_check
      assert (NUM_SLOTS <= WORD_W && CTL_W <= WORD_W)
         else $error("keyslot_vault: control fields exceed word width");
      assert (QUAD_WORDS * (1 << QSEL_W) == WORDS_PER_SLOT)
         else $error("keyslot_vault: slot must hold a power-of-two number of quads");
      assert (KEY_WORDS <= WORDS_PER_SLOT && ACC_W >= 3)
         else $error("keyslot_vault: key or lock width out of range");
      assert (DST_SLOT_LSB >= QSEL_W)
         else $error("keyslot_vault: destination fields overlap");
   end

   logic [NUM_SLOTS*ACC_W-1:0] acc_flat;
   logic [NUM_SLOTS-1:0]       perkey_q;
   logic [SLOT_W-1:0]          ptr_slot;
   logic [WIDX_W-1:0]          ptr_word;
   logic [SLOT_W-1:0]          dst_slot;
   logic [QSEL_W-1:0]          dst_quad;
   logic [WORD_W-1:0]          rd_word_data;
   logic [KEY_BITS-1:0]        key_words;

   keyslot_ctl_regs #(
      .NUM_SLOTS(NUM_SLOTS), .ACC_W(ACC_W), .SLOT_W(SLOT_W), .WIDX_W(WIDX_W),
      .QSEL_W(QSEL_W), .DST_SLOT_LSB(DST_SLOT_LSB), .REG_AW(REG_AW), .CTL_W(CTL_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
      .wr_data(reg_wdata[CTL_W-1:0]), .wr_secure(reg_secure),
      .acc_flat(acc_flat), .perkey_q(perkey_q), .ptr_slot(ptr_slot),
      .ptr_word(ptr_word), .dst_slot(dst_slot), .dst_quad(dst_quad)
   );

   // Permission decode for the three consumers
   logic sw_may_update, sw_may_read, eng_may_update, use_ok;
   always_comb begin
      sw_may_update  = grant(acc_flat[int'(ptr_slot)*ACC_W + ACC_UPDATE],
                             perkey_q[ptr_slot], reg_secure);
      sw_may_read    = grant(acc_flat[int'(ptr_slot)*ACC_W + ACC_READ],
                             perkey_q[ptr_slot], reg_secure);
      eng_may_update = acc_flat[int'(dst_slot)*ACC_W + ACC_UPDATE];
      use_ok         = grant(acc_flat[int'(use_slot)*ACC_W + ACC_USE],
                             perkey_q[use_slot], use_secure);
   end

   keyslot_store #(
      .NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W), .WORDS_PER_SLOT(WORDS_PER_SLOT),
      .QUAD_WORDS(QUAD_WORDS), .KEY_WORDS(KEY_WORDS), .SLOT_W(SLOT_W),
      .WIDX_W(WIDX_W), .QSEL_W(QSEL_W), .ENG_PRIORITY(ENG_PRIORITY)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .sw_we(reg_wr && reg_addr == A_DATA && sw_may_update),
      .sw_slot(ptr_slot), .sw_word(ptr_word), .sw_wdata(reg_wdata),
      .eng_we(eng_we && eng_may_update),
      .eng_slot(dst_slot), .eng_quad(dst_quad), .eng_wdata(eng_data),
      .rd_slot(ptr_slot), .rd_word(ptr_word), .rd_data(rd_word_data),
      .key_slot(use_slot), .key_data(key_words)
   );

   // Read mux
   logic [WORD_W-1:0] rd_next;
   always_comb begin
      rd_next = '0;
      if (reg_addr < A_PTR)
         rd_next[ACC_W-1:0] = acc_flat[int'(reg_addr)*ACC_W +: ACC_W];
      else if (reg_addr == A_PTR)
         rd_next[PTR_W-1:0] = {ptr_slot, ptr_word};
      else if (reg_addr == A_DATA)
         rd_next = sw_may_read ? rd_word_data : '0;
      else if (reg_addr == A_DST) begin
         rd_next[DST_SLOT_LSB +: SLOT_W] = dst_slot;
         rd_next[QSEL_W-1:0]             = dst_quad;
      end else if (reg_addr == A_PKEY)
         rd_next[NUM_SLOTS-1:0] = perkey_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata <= '0;
         use_valid <= 1'b0;
         use_key   <= '0;
      end else begin
         reg_rdata <= reg_rd ? rd_next : '0;
         use_valid <= use_req && use_ok;
         use_key   <= (use_req && use_ok) ? key_words : '0;
      end
   end
endmodule

// File: rtl/keyslot_vault_chk.sv
module keyslot_vault_chk #(
   parameter int unsigned NUM_SLOTS = 16,
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned ACC_W     = 7,
   parameter int unsigned SLOT_W    = 4,
   parameter int unsigned REG_AW    = 5,
   parameter int unsigned KEY_BITS  = 256
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       reg_rd,
   input logic [REG_AW-1:0]          reg_addr,
   input logic [WORD_W-1:0]          reg_rdata,
   input logic [SLOT_W-1:0]          ptr_slot,
   input logic [NUM_SLOTS*ACC_W-1:0] acc_flat,
   input logic [NUM_SLOTS-1:0]       perkey_q,
   input logic                       use_req,
   input logic [SLOT_W-1:0]          use_slot,
   input logic                       use_secure,
   input logic                       use_valid,
   input logic [KEY_BITS-1:0]        use_key
);
   localparam logic [REG_AW-1:0] A_DATA = REG_AW'(NUM_SLOTS + 1);

   assert_access_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_flat & ~$past(acc_flat)) == '0);

   assert_perkey_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (perkey_q & ~$past(perkey_q)) == '0);

   assert_rdata_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> reg_rdata == '0);

   assert_denied_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == A_DATA && !acc_flat[int'(ptr_slot)*ACC_W]) |=> reg_rdata == '0);

   assert_use_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (use_req && !acc_flat[int'(use_slot)*ACC_W + 2]) |=> !use_valid);

   assert_use_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !use_valid |-> use_key == '0);

   assert_use_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
      use_valid |-> $past(use_req));

   assert_perkey_use_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (use_req && !use_secure && !perkey_q[use_slot]) |=> !use_valid);
endmodule

bind keyslot_vault keyslot_vault_chk #(
   .NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W), .ACC_W(ACC_W),
   .SLOT_W(SLOT_W), .REG_AW(REG_AW), .KEY_BITS(KEY_BITS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
   .reg_rdata(reg_rdata), .ptr_slot(ptr_slot), .acc_flat(acc_flat),
   .perkey_q(perkey_q), .use_req(use_req), .use_slot(use_slot),
   .use_secure(use_secure), .use_valid(use_valid), .use_key(use_key)
);

// File: tb/tb_keyslot_vault.sv
module tb_keyslot_vault;
   localparam logic [4:0] A_PTR  = 5'd16;
   localparam logic [4:0] A_DATA = 5'd17;
   localparam logic [4:0] A_DST  = 5'd18;
   localparam logic [4:0] A_PKEY = 5'd19;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_wr = 1'b0, reg_rd = 1'b0, reg_secure = 1'b0;
   logic [4:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic         eng_we = 1'b0;
   logic [127:0] eng_data = '0;
   logic         use_req = 1'b0, use_secure = 1'b0;
   logic [3:0]   use_slot = '0;
   logic         use_valid;
   logic [255:0] use_key;

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   keyslot_vault dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_secure(reg_secure),
      .reg_rdata(reg_rdata), .eng_we(eng_we), .eng_data(eng_data),
      .use_req(use_req), .use_slot(use_slot), .use_secure(use_secure),
      .use_valid(use_valid), .use_key(use_key)
   );

   task automatic check(input string req, input string what,
                        input logic [255:0] act, input logic [255:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic sec);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_secure = sec;
      @(negedge clk);
      reg_wr = 1'b0; reg_secure = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, input logic sec, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a; reg_secure = sec;
      @(negedge clk);
      reg_rd = 1'b0; reg_secure = 1'b0;
      d = reg_rdata;
   endtask

   task automatic put_word(input logic [3:0] s, input logic [3:0] w,
                           input logic [31:0] v, input logic sec);
      wr(A_PTR, {24'h0, s, w}, 1'b0);
      wr(A_DATA, v, sec);
   endtask

   task automatic get_word(input logic [3:0] s, input logic [3:0] w,
                           input logic sec, output logic [31:0] v);
      wr(A_PTR, {24'h0, s, w}, 1'b0);
      rd(A_DATA, sec, v);
   endtask

   task automatic eng_load(input logic [127:0] q);
      @(negedge clk);
      eng_we = 1'b1; eng_data = q;
      @(negedge clk);
      eng_we = 1'b0;
   endtask

   task automatic ask(input logic [3:0] s, input logic sec,
                      output logic v, output logic [255:0] k);
      @(negedge clk);
      use_req = 1'b1; use_slot = s; use_secure = sec;
      @(negedge clk);
      use_req = 1'b0; use_secure = 1'b0;
      v = use_valid; k = use_key;
   endtask

   task automatic t_reset();
      logic [31:0] d; logic v; logic [255:0] k;
      check("R1", "rdata after reset", {224'h0, reg_rdata}, 256'h0);
      check("R1", "use_valid after reset", {255'h0, use_valid}, 256'h0);
      rd(5'd0, 1'b0, d);  check("R1", "access slot0", {224'h0, d}, 256'h7F);
      rd(5'd15, 1'b0, d); check("R1", "access slot15", {224'h0, d}, 256'h7F);
      rd(A_PKEY, 1'b0, d); check("R1", "perkey", {224'h0, d}, 256'hFFFF);
      rd(A_PTR, 1'b0, d);  check("R1", "pointer", {224'h0, d}, 256'h0);
      rd(A_DST, 1'b0, d);  check("R1", "destination", {224'h0, d}, 256'h0);
      get_word(4'd0, 4'd0, 1'b0, d); check("R1", "slot0 word0", {224'h0, d}, 256'h0);
      ask(4'd0, 1'b0, v, k);
      check("R1", "use slot0 valid", {255'h0, v}, 256'h1);
      check("R1", "use slot0 key", k, 256'h0);
   endtask

   task automatic t_sw_path();
      logic [31:0] d;
      put_word(4'd3, 4'd5, 32'hA5A5_0001, 1'b0);
      rd(A_PTR, 1'b0, d); check("R10", "pointer readback", {224'h0, d}, 256'h35);
      rd(A_DATA, 1'b0, d); check("R2", "slot3 word5", {224'h0, d}, 256'hA5A5_0001);
      put_word(4'd15, 4'd15, 32'h0BAD_F00D, 1'b0);
      rd(A_DATA, 1'b0, d); check("R2", "slot15 word15", {224'h0, d}, 256'h0BAD_F00D);
      get_word(4'd3, 4'd5, 1'b0, d); check("R2", "slot3 word5 kept", {224'h0, d}, 256'hA5A5_0001);
      get_word(4'd3, 4'd4, 1'b0, d); check("R2", "slot3 word4 untouched", {224'h0, d}, 256'h0);
   endtask

   task automatic t_engine_and_use();
      logic [31:0] d; logic v; logic [255:0] k; logic [255:0] exp;
      wr(A_DST, 32'h0000_0201, 1'b0);
      rd(A_DST, 1'b0, d); check("R10", "destination readback", {224'h0, d}, 256'h201);
      eng_load({32'h4444_0007, 32'h3333_0006, 32'h2222_0005, 32'h1111_0004});
      get_word(4'd2, 4'd4, 1'b0, d); check("R7", "quad1 lane0 -> word4", {224'h0, d}, 256'h1111_0004);
      get_word(4'd2, 4'd7, 1'b0, d); check("R7", "quad1 lane3 -> word7", {224'h0, d}, 256'h4444_0007);
      get_word(4'd2, 4'd0, 1'b0, d); check("R7", "word0 untouched", {224'h0, d}, 256'h0);
      wr(A_DST, 32'h0000_0203, 1'b0);
      eng_load({32'hDDDD_000F, 32'hCCCC_000E, 32'hBBBB_000D, 32'hAAAA_000C});
      get_word(4'd2, 4'd12, 1'b0, d); check("R7", "quad3 -> word12", {224'h0, d}, 256'hAAAA_000C);
      get_word(4'd2, 4'd15, 1'b0, d); check("R7", "quad3 -> word15", {224'h0, d}, 256'hDDDD_000F);
      wr(A_DST, 32'h0000_0202, 1'b0);
      eng_load({32'h0, 32'h0, 32'h0, 32'h0000_8888});
      get_word(4'd2, 4'd8, 1'b0, d); check("R7", "quad2 -> word8", {224'h0, d}, 256'h8888);
      ask(4'd2, 1'b0, v, k);
      exp = '0;
      exp[4*32 +: 32] = 32'h1111_0004; exp[5*32 +: 32] = 32'h2222_0005;
      exp[6*32 +: 32] = 32'h3333_0006; exp[7*32 +: 32] = 32'h4444_0007;
      check("R8", "use slot2 valid", {255'h0, v}, 256'h1);
      check("R8", "use slot2 key words 0..7", k, exp);
   endtask

   task automatic t_collision();
      logic [31:0] d;
      wr(A_PTR, 32'h59, 1'b0);
      wr(A_DST, 32'h0000_0502, 1'b0);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = A_DATA; reg_wdata = 32'h1111_1111;
      eng_we = 1'b1; eng_data = {32'h4, 32'h3, 32'h2222_2222, 32'h1};
      @(negedge clk);
      reg_wr = 1'b0; eng_we = 1'b0;
      rd(A_DATA, 1'b0, d); check("R9", "engine wins word9", {224'h0, d}, 256'h2222_2222);
      get_word(4'd5, 4'd8, 1'b0, d); check("R9", "word8 from engine", {224'h0, d}, 256'h1);
   endtask

   task automatic t_clear();
      logic [31:0] d; logic [31:0] nz;
      wr(A_DST, 32'h0000_0900, 1'b0); eng_load({4{32'hFFFF_FFFF}});
      wr(A_DST, 32'h0000_0903, 1'b0); eng_load({4{32'h1234_5678}});
      for (int w = 0; w < 16; w++) put_word(4'd9, 4'(w), 32'h0, 1'b0);
      nz = 32'h0;
      for (int w = 0; w < 16; w++) begin
         get_word(4'd9, 4'(w), 1'b0, d);
         nz = nz | d;
      end
      check("R2", "slot9 cleared word by word", {224'h0, nz}, 256'h0);
   endtask

   task automatic t_locks();
      logic [31:0] d; logic v; logic [255:0] k; logic [255:0] exp;
      put_word(4'd6, 4'd0, 32'h0000_CAFE, 1'b0);
      wr(5'd6, 32'hFFFF_FF7D, 1'b0);
      rd(5'd6, 1'b0, d); check("R5", "update bit cleared", {224'h0, d}, 256'h7D);
      put_word(4'd6, 4'd0, 32'h0000_DEAD, 1'b0);
      rd(A_DATA, 1'b0, d); check("R4", "denied sw write dropped", {224'h0, d}, 256'hCAFE);
      wr(A_DST, 32'h0000_0600, 1'b0);
      eng_load({4{32'h5555_5555}});
      get_word(4'd6, 4'd0, 1'b0, d); check("R4", "denied engine write dropped", {224'h0, d}, 256'hCAFE);
      wr(5'd6, 32'h0000_007F, 1'b0);
      rd(5'd6, 1'b0, d); check("R5", "cleared bit stays clear", {224'h0, d}, 256'h7D);
      wr(5'd6, 32'h0000_0074, 1'b0);
      rd(5'd6, 1'b0, d); check("R5", "reserved bits kept, read cleared", {224'h0, d}, 256'h74);
      get_word(4'd6, 4'd0, 1'b0, d); check("R3", "denied read gives zero", {224'h0, d}, 256'h0);
      ask(4'd6, 1'b0, v, k);
      exp = '0; exp[31:0] = 32'h0000_CAFE;
      check("R4", "key intact through use port", k, exp);
      check("R8", "use still granted", {255'h0, v}, 256'h1);
      wr(5'd6, 32'h0, 1'b0);
      ask(4'd6, 1'b1, v, k);
      check("R8", "use denied when use bit clear", {255'h0, v}, 256'h0);
      check("R8", "key zero when denied", k, 256'h0);
      rd(5'd6, 1'b0, d); check("R5", "fully locked", {224'h0, d}, 256'h0);
   endtask

   task automatic t_perkey();
      logic [31:0] d; logic v; logic [255:0] k; logic [255:0] exp;
      put_word(4'd7, 4'd1, 32'h0000_0077, 1'b0);
      wr(A_PKEY, 32'h0000_FF7F, 1'b0);
      rd(A_PKEY, 1'b0, d); check("R6", "non-secure perkey write ignored", {224'h0, d}, 256'hFFFF);
      wr(A_PKEY, 32'h0000_FF7F, 1'b1);
      rd(A_PKEY, 1'b0, d); check("R6", "secure perkey clear", {224'h0, d}, 256'hFF7F);
      rd(A_DATA, 1'b0, d); check("R6", "non-secure read refused", {224'h0, d}, 256'h0);
      rd(A_DATA, 1'b1, d); check("R6", "secure read served", {224'h0, d}, 256'h77);
      wr(A_DATA, 32'h0000_0099, 1'b0);
      rd(A_DATA, 1'b1, d); check("R6", "non-secure write refused", {224'h0, d}, 256'h77);
      wr(A_DATA, 32'h0000_00AB, 1'b1);
      rd(A_DATA, 1'b1, d); check("R6", "secure write served", {224'h0, d}, 256'hAB);
      ask(4'd7, 1'b0, v, k);
      check("R6", "non-secure use refused", {255'h0, v}, 256'h0);
      ask(4'd7, 1'b1, v, k);
      exp = '0; exp[63:32] = 32'h0000_00AB;
      check("R6", "secure use granted", {255'h0, v}, 256'h1);
      check("R8", "secure use key", k, exp);
      wr(A_PKEY, 32'h0000_FFFF, 1'b1);
      rd(A_PKEY, 1'b0, d); check("R6", "perkey cannot be reopened", {224'h0, d}, 256'hFF7F);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         compared++; mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sw_path();
      t_engine_and_use();
      t_collision();
      t_clear();
      t_locks();
      t_perkey();
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule